// File: doc/BRIEF.md
# Persistent Quadrature Up/Down Counter Engine

This block keeps a signed counter in a six-byte record that lives in a small external byte memory. A single command strobe starts one update. The engine first reads the whole record one byte per cycle. It then decides whether the update may go ahead. If it may, it computes the new value and writes the record back. The memory therefore holds the counter, a 2-bit status flag and, in position mode, the last quadrature code. The count survives any loss of the engine's own state.

The engine has two modes. In position mode the caller supplies the new 2-bit quadrature code. The engine compares it with the stored code to decide between one step up, one step down or no step, and it uses a 43-bit two's-complement counter. In direct mode the caller asks for +1 or -1 explicitly, and the counter is 46 bits wide.

A nonzero status flag freezes the counter, and so does a mismatch between the two stored copies of the direction bit. The flag records a signed wrap and also marks an update that was cut off part way. The memory port has an asynchronous (same-cycle) read path and a write strobe.

Top module: `qcnt_engine`

## Requirements
- R1: After reset `ready` is 1, `done` is 0 and `mem_we` is 0.
- R2: When `cmd_go` is high while `ready` is high, `ready` drops on the next cycle. A completed update keeps `ready` low for exactly 14 cycles: 6 reads, 1 decision and 7 writes. It then raises `ready` together with a one-cycle `done` pulse.
- R3: Direct mode (`cmd_direct`=1) treats the record as bits [45:0] = counter and bits [47:46] = flag, where record bit 8k+j is bit j of byte k. It adds 1 when `cmd_down`=0 and subtracts 1 when `cmd_down`=1.
- R4: Position mode (`cmd_direct`=0) steps up when the stored code goes to `new_pos` along 00→01→11→10→00. It steps down for the reverse moves. Every other pair, including an unchanged code, leaves the count as it is but still completes the update.
- R5: Position-mode record layout:
  - bit 0 holds the code's low bit and bit 1 holds its direction bit.
  - bits [44:2] hold the counter and bit 45 holds the copy of the direction bit.
  - bits [47:46] hold the flag.
  - A completed update writes `new_pos` into bits [1:0] and `new_pos[1]` into bit 45.
- R6: If the stored flag is not 00, the update aborts. Nothing is written, `ready` stays low for exactly 7 cycles and `done` still pulses.
- R7: In position mode the update also aborts, as in R6, when record bit 1 differs from bit 45.
- R8: A step up from the largest positive value, or a step down from the most negative value, wraps the counter and writes flag 01. Any other completed update writes flag 00.
- R9: The first write of an update goes to byte 5 with flag 11 in bits [7:6]. It is followed by writes to bytes 0 to 5 in ascending order. All writes address bytes 0 to 5 only.
- R10: `cmd_go` and the command inputs are ignored while `ready` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_go | input | 1 | Start strobe, accepted only while ready |
| cmd_direct | input | 1 | 1 = direct mode, 0 = position mode |
| cmd_down | input | 1 | Direct mode: 1 = decrement, 0 = increment |
| new_pos | input | 2 | Position mode: new code {direction bit, low bit} |
| ready | output | 1 | High while idle, low during an update |
| done | output | 1 | One-cycle pulse when an update finishes or aborts |
| mem_addr | output | ADDR_W | Record byte address |
| mem_we | output | 1 | Write strobe |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data for `mem_addr`, same cycle |

## Verification
The bench builds the engine with its default parameters: a six-byte record, 11-bit addresses and the in-progress marker enabled. Both counter widths are reached at their full size by preloading the bench's memory model. The record can be set directly to the largest positive and most negative values, to every flag code and to a mismatched direction copy. The wrap, freeze and abort paths are therefore exercised in single updates, without millions of counting steps.

// File: rtl/qcnt_pkg.sv
package qcnt_pkg;
   typedef enum logic [1:0] {STEP_NONE, STEP_UP, STEP_DOWN} step_t;
   typedef enum logic [1:0] {S_IDLE, S_READ, S_CHECK, S_WRITE} state_t;
   localparam logic [1:0] EF_OK   = 2'b00;
   localparam logic [1:0] EF_WRAP = 2'b01;
   localparam logic [1:0] EF_OPEN = 2'b11;
endpackage

// File: rtl/qcnt_pos_decode.sv
module qcnt_pos_decode
   import qcnt_pkg::*;
(
   input  logic [1:0] old_code,
   input  logic [1:0] new_code,
   output step_t      step
);
   // forward sequence 00 -> 01 -> 11 -> 10 -> 00
   always_comb begin
      case ({old_code, new_code})
         4'b0001, 4'b0111, 4'b1110, 4'b1000: step = STEP_UP;
         4'b0100, 4'b1101, 4'b1011, 4'b0010: step = STEP_DOWN;
         default:                            step = STEP_NONE;
      endcase
   end
endmodule

// File: rtl/qcnt_step.sv
module qcnt_step
   import qcnt_pkg::*;
#(
   parameter int W = 46
) (
   input  logic [W-1:0] cnt,
   input  step_t        step,
   output logic [W-1:0] nxt,
   output logic         wrapped
);
   if (W < 2) begin : g_bad_w
      $error("qcnt_step: W must be at least 2");
   end

   always_comb begin
      case (step)
         STEP_UP: begin
            nxt     = cnt + W'(1);
            wrapped = !cnt[W-1] && nxt[W-1];
         end
         STEP_DOWN: begin
            nxt     = cnt - W'(1);
            wrapped = cnt[W-1] && !nxt[W-1];
         end
         default: begin
            nxt     = cnt;
            wrapped = 1'b0;
         end
      endcase
   end
endmodule

// File: rtl/qcnt_engine.sv
module qcnt_engine
   import qcnt_pkg::*;
#(
   parameter int ADDR_W    = 11,
   parameter int REC_BYTES = 6,
   parameter bit OPEN_MARK = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_go,
   input  logic              cmd_direct,
   input  logic              cmd_down,
   input  logic [1:0]        new_pos,
   output logic              ready,
   output logic              done,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              mem_we,
   output logic [7:0]        mem_wdata,
   input  logic [7:0]        mem_rdata
);
   localparam int RECW     = 8 * REC_BYTES;
   localparam int DW       = RECW - 2;
   localparam int PW       = RECW - 5;
   localparam int LAST     = REC_BYTES - 1;
   localparam int WR_STEPS = REC_BYTES + (OPEN_MARK ? 1 : 0);
   localparam int IDX_W    = $clog2(REC_BYTES + 2);

   if (REC_BYTES < 2) begin : g_bad_rec
      $error("qcnt_engine: REC_BYTES must be at least 2");
   end
   if ((1 << ADDR_W) < REC_BYTES) begin : g_bad_addr
      $error("qcnt_engine: ADDR_W too small for the record");
   end

   state_t            state;
   logic [IDX_W-1:0]  idx;
   logic [RECW-1:0]   rec;
   logic              direct_q, down_q;
   logic [1:0]        pos_q;

   // field views of the captured record
   logic [1:0]    ef;
   logic [1:0]    p_code;
   logic          p_dirp;
   logic [PW-1:0] p_cnt, p_nxt;
   logic [DW-1:0] d_cnt, d_nxt;
   logic          p_wrap, d_wrap, abort;
   step_t         p_step, d_step;
   logic [RECW-1:0] new_rec;

   assign ef     = rec[RECW-1 -: 2];
   assign p_code = rec[1:0];
   assign p_dirp = rec[RECW-3];
   assign p_cnt  = rec[PW+1:2];
   assign d_cnt  = rec[DW-1:0];
   assign d_step = down_q ? STEP_DOWN : STEP_UP;
   assign abort  = (ef != EF_OK) || (!direct_q && (p_code[1] != p_dirp));

   qcnt_pos_decode u_dec (.old_code(p_code), .new_code(pos_q), .step(p_step));
   qcnt_step #(.W(PW)) u_pstep (.cnt(p_cnt), .step(p_step), .nxt(p_nxt), .wrapped(p_wrap));
   qcnt_step #(.W(DW)) u_dstep (.cnt(d_cnt), .step(d_step), .nxt(d_nxt), .wrapped(d_wrap));

   always_comb begin
      if (direct_q) new_rec = {(d_wrap ? EF_WRAP : EF_OK), d_nxt};
      else          new_rec = {(p_wrap ? EF_WRAP : EF_OK), pos_q[1], p_nxt, pos_q};
   end

   // write-phase variant: optional in-progress marker ahead of the bytes
   logic             mark_now;
   logic [IDX_W-1:0] wr_byte;
   if (OPEN_MARK) begin : g_mark
      assign mark_now = (state == S_WRITE) && (idx == '0);
      assign wr_byte  = idx - IDX_W'(1);
   end else begin : g_plain
      assign mark_now = 1'b0;
      assign wr_byte  = idx;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= S_IDLE;
         idx      <= '0;
         rec      <= '0;
         direct_q <= 1'b0;
         down_q   <= 1'b0;
         pos_q    <= '0;
         done     <= 1'b0;
      end else begin
         done <= 1'b0;
         case (state)
            S_IDLE: if (cmd_go) begin
               direct_q <= cmd_direct;
               down_q   <= cmd_down;
               pos_q    <= new_pos;
               idx      <= '0;
               state    <= S_READ;
            end
            S_READ: begin
               for (int b = 0; b < REC_BYTES; b++)
                  if (idx == IDX_W'(b)) rec[8*b +: 8] <= mem_rdata;
               if (idx == IDX_W'(LAST)) begin
                  idx   <= '0;
                  state <= S_CHECK;
               end else begin
                  idx <= idx + IDX_W'(1);
               end
            end
            S_CHECK: begin
               if (abort) begin
                  state <= S_IDLE;
                  done  <= 1'b1;
               end else begin
                  rec   <= new_rec;
                  idx   <= '0;
                  state <= S_WRITE;
               end
            end
            default: begin
               if (idx == IDX_W'(WR_STEPS - 1)) begin
                  state <= S_IDLE;
                  done  <= 1'b1;
               end else begin
                  idx <= idx + IDX_W'(1);
               end
            end
         endcase
      end
   end

   assign ready = (state == S_IDLE);

   always_comb begin
      mem_we    = 1'b0;
      mem_addr  = '0;
      mem_wdata = '0;
      if (state == S_READ) begin
         mem_addr = ADDR_W'(idx);
      end else if (state == S_WRITE) begin
         mem_we = 1'b1;
         if (mark_now) begin
            mem_addr  = ADDR_W'(LAST);
            mem_wdata = {EF_OPEN, rec[RECW-3 -: 6]};
         end else begin
            mem_addr = ADDR_W'(wr_byte);
            for (int b = 0; b < REC_BYTES; b++)
               if (wr_byte == IDX_W'(b)) mem_wdata = rec[8*b +: 8];
         end
      end
   end
endmodule

// File: rtl/qcnt_engine_checker.sv
module qcnt_engine_checker #(
   parameter int ADDR_W    = 11,
   parameter int REC_BYTES = 6,
   parameter bit OPEN_MARK = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cmd_go,
   input logic              ready,
   input logic              done,
   input logic              mem_we,
   input logic [ADDR_W-1:0] mem_addr,
   input logic [7:0]        mem_wdata
);
   assert_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (ready && cmd_go) |=> !ready);
   assert_stay_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (ready && !cmd_go) |=> ready);
   assert_done_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   assert_done_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> ready);
   assert_write_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> !ready);
   assert_addr_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> (mem_addr < ADDR_W'(REC_BYTES)));

   if (OPEN_MARK) begin : g_mark_chk
      assert_open_first_R9: assert property (@(posedge clk) disable iff (!rst_n)
         (mem_we && !$past(mem_we)) |->
            (mem_addr == ADDR_W'(REC_BYTES - 1) && mem_wdata[7:6] == 2'b11));
   end
endmodule

bind qcnt_engine qcnt_engine_checker #(
   .ADDR_W(ADDR_W), .REC_BYTES(REC_BYTES), .OPEN_MARK(OPEN_MARK)
) u_chk (
   .clk(clk), .rst_n(rst_n), .cmd_go(cmd_go), .ready(ready), .done(done),
   .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata)
);

// File: tb/qcnt_engine_bench.sv
module qcnt_engine_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cmd_go = 1'b0, cmd_direct = 1'b0, cmd_down = 1'b0;
   logic [1:0]  new_pos = 2'b00;
   logic        ready, done, mem_we;
   logic [10:0] mem_addr;
   logic [7:0]  mem_wdata, mem_rdata;
   logic [7:0]  mem [0:7];

   always #5 clk = ~clk;

   qcnt_engine u_qcnt_engine (
      .clk(clk), .rst_n(rst_n), .cmd_go(cmd_go), .cmd_direct(cmd_direct),
      .cmd_down(cmd_down), .new_pos(new_pos), .ready(ready), .done(done),
      .mem_addr(mem_addr), .mem_we(mem_we), .mem_wdata(mem_wdata),
      .mem_rdata(mem_rdata)
   );

   assign mem_rdata = mem[mem_addr[2:0]];
   always @(posedge clk) if (mem_we) mem[mem_addr[2:0]] <= mem_wdata;

   int n_run = 0, n_fail = 0;
   logic [47:0] q_rec[$];
   int          q_cyc[$];
   int          q_wr[$];
   string       q_tag[$];

   task automatic chk(input bit ok, input string tag, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
      end
   endtask

   function automatic logic [1:0] gray_next(input logic [1:0] c);
      case (c)
         2'b00: return 2'b01;
         2'b01: return 2'b11;
         2'b11: return 2'b10;
         default: return 2'b00;
      endcase
   endfunction

   function automatic logic [47:0] rec_now();
      return {mem[5], mem[4], mem[3], mem[2], mem[1], mem[0]};
   endfunction

   // driver: compute the expectation, push it, preload memory, issue the command
   task automatic run_op(input logic [47:0] init, input bit dm, input bit dn,
                         input logic [1:0] np, input string tag, input bit poke);
      logic [47:0] exp;
      logic [45:0] dc;
      logic [42:0] pc;
      logic        ovf;
      int          stp;
      bit          ab;
      exp = init;
      if (dm) begin
         ab = (init[47:46] != 2'b00);
         dc = init[45:0];
         if (!ab) begin
            if (!dn) begin ovf = (dc == 46'h1FFF_FFFF_FFFF); dc = dc + 46'd1; end
            else     begin ovf = (dc == 46'h2000_0000_0000); dc = dc - 46'd1; end
            exp = {ovf ? 2'b01 : 2'b00, dc};
         end
      end else begin
         ab = (init[47:46] != 2'b00) || (init[1] != init[45]);
         pc = init[44:2];
         if (!ab) begin
            stp = 0;
            if (gray_next(init[1:0]) == np) stp = 1;
            else if (gray_next(np) == init[1:0]) stp = -1;
            ovf = 1'b0;
            if (stp == 1)  begin ovf = (pc == 43'h3FF_FFFF_FFFF); pc = pc + 43'd1; end
            if (stp == -1) begin ovf = (pc == 43'h400_0000_0000); pc = pc - 43'd1; end
            exp = {ovf ? 2'b01 : 2'b00, np[1], pc, np};
         end
      end
      q_rec.push_back(exp);
      q_cyc.push_back(ab ? 7 : 14);
      q_wr.push_back(ab ? 0 : 7);
      q_tag.push_back(tag);
      for (int b = 0; b < 6; b++) mem[b] = init[8*b +: 8];
      @(negedge clk);
      cmd_direct = dm; cmd_down = dn; new_pos = np; cmd_go = 1'b1;
      @(negedge clk);
      cmd_go = 1'b0;
      if (poke) begin
         repeat (3) @(negedge clk);
         cmd_direct = ~dm; cmd_down = ~dn; new_pos = ~np; cmd_go = 1'b1;
         @(negedge clk);
         cmd_go = 1'b0;
      end
      while (!done) @(negedge clk);
      @(negedge clk);
   endtask

   // monitor: count busy cycles and writes, compare when done pulses
   initial begin
      int busy, wr;
      logic [10:0] fa;
      logic [7:0]  fd;
      logic [47:0] er;
      int ec, ew;
      string t;
      busy = 0; wr = 0; fa = '0; fd = '0;
      forever begin
         @(negedge clk);
         if (rst_n) begin
            if (!ready) busy++;
            if (mem_we) begin
               if (wr == 0) begin fa = mem_addr; fd = mem_wdata; end
               wr++;
            end
            if (done) begin
               if (q_rec.size() == 0) begin
                  chk(1'b0, "R2", "unexpected done", 64'd1, 64'd0);
               end else begin
                  er = q_rec.pop_front(); ec = q_cyc.pop_front();
                  ew = q_wr.pop_front();  t = q_tag.pop_front();
                  chk(rec_now() == er, t, "record", 64'(rec_now()), 64'(er));
                  chk(busy == ec, {t, " R2"}, "busy cycles", 64'(busy), 64'(ec));
                  chk(wr == ew, {t, " R9"}, "write count", 64'(wr), 64'(ew));
                  if (wr > 0)
                     chk(fa == 11'd5 && fd[7:6] == 2'b11, {t, " R9"}, "first write",
                         64'({fa, fd}), 64'({11'd5, 2'b11, fd[5:0]}));
               end
               busy = 0; wr = 0;
            end
         end
      end
   end

   task automatic finish_run();
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      chk(1'b0, "watchdog", "timeout", 64'd1, 64'd0);
      finish_run();
   end

   initial begin
      for (int b = 0; b < 8; b++) mem[b] = 8'h00;
      repeat (3) @(negedge clk);
      chk(ready == 1'b1, "R1", "ready at reset", 64'(ready), 64'd1);
      chk(done == 1'b0, "R1", "done at reset", 64'(done), 64'd0);
      chk(mem_we == 1'b0, "R1", "mem_we at reset", 64'(mem_we), 64'd0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk(ready == 1'b1, "R1", "ready idle", 64'(ready), 64'd1);

      // direct mode
      run_op({2'b00, 46'h123},           1, 0, 2'b00, "R3 direct up", 0);
      run_op({2'b00, 46'h0},             1, 1, 2'b00, "R3 direct down through zero", 0);
      run_op({2'b00, 46'h1FFF_FFFF_FFFF}, 1, 0, 2'b00, "R8 direct wrap up", 0);
      run_op({2'b00, 46'h2000_0000_0000}, 1, 1, 2'b00, "R8 direct wrap down", 0);
      run_op({2'b01, 46'h55},            1, 0, 2'b00, "R6 direct frozen by flag 01", 0);
      run_op({2'b11, 46'h77},            1, 1, 2'b00, "R6 direct frozen by flag 11", 0);

      // position mode: {ef, dir', cnt43, dir, pp}
      run_op({2'b00, 1'b0, 43'd5, 2'b00},  0, 0, 2'b01, "R4 R5 pos 00 to 01 up", 0);
      run_op({2'b00, 1'b0, 43'd5, 2'b01},  0, 0, 2'b00, "R4 R5 pos 01 to 00 down", 0);
      run_op({2'b00, 1'b1, 43'd9, 2'b10},  0, 0, 2'b00, "R4 pos 10 to 00 up", 0);
      run_op({2'b00, 1'b1, 43'd9, 2'b11},  0, 0, 2'b11, "R4 pos unchanged code", 0);
      run_op({2'b00, 1'b0, 43'd9, 2'b00},  0, 0, 2'b11, "R4 pos skipped code", 0);
      run_op({2'b00, 1'b1, 43'd3, 2'b00},  0, 0, 2'b01, "R7 pos direction copy mismatch", 0);
      run_op({2'b10, 1'b0, 43'd3, 2'b00},  0, 0, 2'b01, "R6 pos frozen by flag 10", 0);
      run_op({2'b00, 1'b1, 43'h3FF_FFFF_FFFF, 2'b11}, 0, 0, 2'b10, "R8 pos wrap up", 0);
      run_op({2'b00, 1'b0, 43'h400_0000_0000, 2'b00}, 0, 0, 2'b10, "R8 pos wrap down", 0);

      // strobe while busy must not alter or restart the update
      run_op({2'b00, 46'h1000},          1, 0, 2'b00, "R10 go while busy", 1);
      chk(ready == 1'b1, "R10", "idle after poke", 64'(ready), 64'd1);
      chk(q_rec.size() == 0, "R10", "pending items", 64'(q_rec.size()), 64'd0);

      repeat (5) @(negedge clk);
      finish_run();
   end
endmodule